// File: doc/BRIEF.md
# Receive Queue with Fill Trigger, Error Tallies and Idle Flag

This block buffers characters delivered by a serial receiver until a host drains them. Each stored entry carries an 8-bit data byte, the ID (address) bit that came with the character, and that character's own parity-error and framing-error bits. The receiver pushes one entry per character. The host pops the oldest entry when it reads the low byte of the head. Reading the high part first, which holds the ID bit and the flags, has no side effect, so that part is simply the combinational head view.

Beyond plain storage, the block does four things. It compares the fill level against a programmable trigger level and raises a threshold flag. It keeps running tallies of how many stored entries carry a framing error and how many carry a parity error. It raises a data-ready flag when characters sit below the trigger with no new arrival for a programmable number of bit periods. It drives an active-low flow-control output from a second trigger level. It also records an overrun when a character arrives while every slot is occupied. A flush input empties the queue in one cycle.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to DEPTH (default 16) entries in arrival order. `count_o` gives the number stored. A pop (`rd_lo_i`) on an empty queue is ignored.
- R2: `head_data_o`, `head_id_o`, `head_per_o` and `head_fer_o` show the oldest stored entry's fields. They are all zero when the queue is empty.
- R3: A push is stored only while count is below DEPTH. A push while count equals DEPTH is discarded, even if a pop happens in the same cycle, and it sets the sticky `overrun_o` on the next cycle.
- R4: `trig_hit_o` is 1 exactly when count is greater than or equal to the unsigned `trig_lvl_i`.
- R5: `fer_cnt_o` and `per_cnt_o` equal the number of stored entries whose framing or parity bit is 1. They stay correct when a push and a pop occur in the same cycle.
- R6: An idle counter restarts to zero on any push or whenever the queue is empty. Otherwise it advances by one on each `bit_tick_i` pulse while `rx_busy_i` is low, and it saturates at IDLE_BITS. `data_ready_o` is 1 only when all of these hold: the counter equals IDLE_BITS, count is nonzero, count is at or below `trig_lvl_i`, and `rx_busy_i` is low.
- R7: `flush_i` takes priority over push and pop in the same cycle. On the next cycle, count, both error tallies, the idle counter and `overrun_o` are all zero.
- R8: `rts_no` is 1 (deasserted) while count is greater than or equal to `rts_lvl_i`, and 0 while count is below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue and clear overrun |
| push_i | input | 1 | Receiver delivers one character |
| push_data_i | input | 8 | Character data |
| push_id_i | input | 1 | ID bit of the character |
| push_per_i | input | 1 | Parity error on the character |
| push_fer_i | input | 1 | Framing error on the character |
| rd_lo_i | input | 1 | Host low-byte read; pops the head |
| bit_tick_i | input | 1 | One pulse per bit period |
| rx_busy_i | input | 1 | Receiver is mid-character |
| trig_lvl_i | input | 5 | Receive trigger level |
| rts_lvl_i | input | 5 | Flow-control trigger level |
| head_data_o | output | 8 | Head entry data |
| head_id_o | output | 1 | Head entry ID bit |
| head_per_o | output | 1 | Head entry parity error |
| head_fer_o | output | 1 | Head entry framing error |
| count_o | output | 5 | Number of stored entries |
| trig_hit_o | output | 1 | Count at or above trigger |
| fer_cnt_o | output | 5 | Stored entries with framing error |
| per_cnt_o | output | 5 | Stored entries with parity error |
| data_ready_o | output | 1 | Idle timeout with data below trigger |
| rts_no | output | 1 | Flow control, active low |
| overrun_o | output | 1 | Sticky overrun |

## Verification
The assertions check every cycle that the count stays bounded and moves by at most one without a flush, and that a flush empties the queue. They also check that the error tallies never exceed the count and never go below zero on a pop, that overrun only rises after a push into a full queue, that a push restarts the idle counter, and that data-ready never shows while the queue is empty or the receiver is busy. Only the bench's cycle-by-cycle reference queue can show the rest: arrival order and head contents, the exact tally values under concurrent push and pop, the idle timeout length, and the trigger and flow-control thresholds.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int unsigned DATA_W = 8;

  typedef struct packed {
    logic              id;
    logic              per;
    logic              fer;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  rxq_entry_t       push_entry_i,
  input  logic             pop_i,
  output rxq_entry_t       head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             overrun_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rxq_entry_t       slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             overrun_q;
  logic             full, empty;

  assign full      = (count_q == FULL_CNT);
  assign empty     = (count_q == '0);
  assign push_ok_o = push_i && !flush_i && !full;
  assign pop_ok_o  = pop_i && !flush_i && !empty;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (push_ok_o && wr_ptr_q == PTR_W'(g)) slot_q[g] <= push_entry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      count_q   <= '0;
      overrun_q <= 1'b0;
    end else if (flush_i) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      count_q   <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (push_ok_o) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok_o)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      count_q <= count_q + CNT_W'(push_ok_o) - CNT_W'(pop_ok_o);
      if (push_i && full) overrun_q <= 1'b1;
    end
  end

  assign head_o    = empty ? '0 : slot_q[rd_ptr_q];
  assign count_o   = count_q;
  assign overrun_o = overrun_q;

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (count_q <= $past(count_q) + 1'b1) && (count_q + 1'b1 >= $past(count_q)));
  p_ovr_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_q) |-> $past(push_i && full));
  p_flush_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0) && !overrun_q);
endmodule

// File: rtl/rxq_err_tally.sv
module rxq_err_tally #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_ok_i,
  input  logic             push_fer_i,
  input  logic             push_per_i,
  input  logic             pop_ok_i,
  input  logic             head_fer_i,
  input  logic             head_per_i,
  output logic [CNT_W-1:0] fer_cnt_o,
  output logic [CNT_W-1:0] per_cnt_o
);
  localparam int unsigned N_KIND = 2; // 0: framing, 1: parity

  logic [N_KIND-1:0] inc, dec;
  logic [CNT_W-1:0]  cnt_q [N_KIND];

  assign inc = {push_ok_i && push_per_i, push_ok_i && push_fer_i};
  assign dec = {pop_ok_i && head_per_i,  pop_ok_i && head_fer_i};

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q[k] <= '0;
      else if (flush_i) cnt_q[k] <= '0;
      else              cnt_q[k] <= cnt_q[k] + CNT_W'(inc[k]) - CNT_W'(dec[k]);
    end

    p_err_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec[k] |-> cnt_q[k] != '0);
  end

  assign fer_cnt_o = cnt_q[0];
  assign per_cnt_o = cnt_q[1];
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int unsigned IDLE_BITS = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic push_i,
  input  logic nonempty_i,
  input  logic bit_tick_i,
  input  logic rx_busy_i,
  output logic expired_o
);
  localparam int unsigned IW = $clog2(IDLE_BITS + 1);
  localparam logic [IW-1:0] LIMIT = IW'(IDLE_BITS);

  logic [IW-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  idle_q <= '0;
    else if (flush_i || push_i || !nonempty_i)   idle_q <= '0;
    else if (bit_tick_i && !rx_busy_i && idle_q != LIMIT) idle_q <= idle_q + 1'b1;
  end

  assign expired_o = (idle_q == LIMIT);

  p_idle_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> idle_q == '0);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned IDLE_BITS = 15,
  parameter int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_id_i,
  input  logic              push_per_i,
  input  logic              push_fer_i,
  input  logic              rd_lo_i,
  input  logic              bit_tick_i,
  input  logic              rx_busy_i,
  input  logic [CNT_W-1:0]  trig_lvl_i,
  input  logic [CNT_W-1:0]  rts_lvl_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_id_o,
  output logic              head_per_o,
  output logic              head_fer_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              trig_hit_o,
  output logic [CNT_W-1:0]  fer_cnt_o,
  output logic [CNT_W-1:0]  per_cnt_o,
  output logic              data_ready_o,
  output logic              rts_no,
  output logic              overrun_o
);
  rxq_entry_t       push_entry, head;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok, expired;

  assign push_entry = '{id: push_id_i, per: push_per_i, fer: push_fer_i, data: push_data_i};

  rxq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk_i, .rst_ni, .flush_i, .push_i,
    .push_entry_i (push_entry),
    .pop_i        (rd_lo_i),
    .head_o       (head),
    .count_o      (count),
    .push_ok_o    (push_ok),
    .pop_ok_o     (pop_ok),
    .overrun_o
  );

  rxq_err_tally #(.CNT_W(CNT_W)) u_tally (
    .clk_i, .rst_ni, .flush_i,
    .push_ok_i  (push_ok),
    .push_fer_i,
    .push_per_i,
    .pop_ok_i   (pop_ok),
    .head_fer_i (head.fer),
    .head_per_i (head.per),
    .fer_cnt_o,
    .per_cnt_o
  );

  rxq_idle_timer #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i, .rst_ni, .flush_i, .push_i,
    .nonempty_i (count != '0),
    .bit_tick_i,
    .rx_busy_i,
    .expired_o  (expired)
  );

  assign head_data_o  = head.data;
  assign head_id_o    = head.id;
  assign head_per_o   = head.per;
  assign head_fer_o   = head.fer;
  assign count_o      = count;
  assign trig_hit_o   = (count >= trig_lvl_i);
  assign rts_no       = (count >= rts_lvl_i);
  assign data_ready_o = expired && (count != '0) && (count <= trig_lvl_i) && !rx_busy_i;

  p_err_le_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fer_cnt_o <= count) && (per_cnt_o <= count));
  p_dr_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> (count != '0) && !rx_busy_i);
  p_empty_head_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0) |-> (head == '0));
endmodule

// File: tb/rxq_top_tb_top.sv
module rxq_top_tb_top;
  localparam int DEPTH = 16;
  localparam int IDLE  = 15;
  localparam int CW    = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          flush_i = 0, push_i = 0, push_id_i = 0, push_per_i = 0, push_fer_i = 0;
  logic [7:0]    push_data_i = '0;
  logic          rd_lo_i = 0, bit_tick_i = 0, rx_busy_i = 0;
  logic [CW-1:0] trig_lvl_i = '0, rts_lvl_i = '0;
  logic [7:0]    head_data_o;
  logic          head_id_o, head_per_o, head_fer_o, trig_hit_o, data_ready_o, rts_no, overrun_o;
  logic [CW-1:0] count_o, fer_cnt_o, per_cnt_o;

  rxq_top dut_i (.*);

  always #10 clk_i = ~clk_i;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference state; entry packing {id, per, fer, data[7:0]}
  logic [10:0] q[$];
  int  idle = 0;
  bit  ovr = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int n = q.size();
    int nf = 0, np = 0;
    logic [10:0] h = (n > 0) ? q[0] : 11'd0;
    foreach (q[i]) begin
      nf += int'(q[i][8]);
      np += int'(q[i][9]);
    end
    chk("R1 count", int'(count_o), n);
    chk("R2 head", int'({head_id_o, head_per_o, head_fer_o, head_data_o}), int'(h));
    chk("R3 overrun", int'(overrun_o), int'(ovr));
    chk("R4 trigger", int'(trig_hit_o), int'(n >= int'(trig_lvl_i)));
    chk("R5 fer tally", int'(fer_cnt_o), nf);
    chk("R5 per tally", int'(per_cnt_o), np);
    chk("R6 data ready", int'(data_ready_o),
        int'(idle == IDLE && n > 0 && n <= int'(trig_lvl_i) && !rx_busy_i));
    chk("R8 rts", int'(rts_no), int'(n >= int'(rts_lvl_i)));
  endtask

  task automatic model_update();
    int n = q.size();
    if (flush_i) begin
      q.delete();
      ovr = 0;
      idle = 0;
    end else begin
      if (push_i) idle = 0;
      else if (n == 0) idle = 0;
      else if (bit_tick_i && !rx_busy_i && idle < IDLE) idle++;
      if (push_i && n == DEPTH) ovr = 1;
      if (rd_lo_i && n > 0) void'(q.pop_front());
      if (push_i && n < DEPTH) q.push_back({push_id_i, push_per_i, push_fer_i, push_data_i});
    end
  endtask

  // called at a negedge: drive, settle, compare, advance model, wait next negedge
  task automatic cyc(input bit fl, input bit pu, input logic [7:0] d, input bit id,
                     input bit pe, input bit fe, input bit po, input bit tk, input bit bz);
    flush_i = fl; push_i = pu; push_data_i = d; push_id_i = id;
    push_per_i = pe; push_fer_i = fe; rd_lo_i = po; bit_tick_i = tk; rx_busy_i = bz;
    #1;
    compare();
    model_update();
    @(negedge clk_i);
  endtask

  task automatic idle_cyc();
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    trig_lvl_i = 5'd8;
    rts_lvl_i  = 5'd12;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // reset state
    chk("R1 reset count", int'(count_o), 0);
    chk("R2 reset head", int'(head_data_o), 0);
    chk("R3 reset overrun", int'(overrun_o), 0);
    chk("R6 reset data ready", int'(data_ready_o), 0);
    @(negedge clk_i);

    // pop on empty ignored
    cyc(0, 0, 8'h00, 0, 0, 0, 1, 0, 0);
    idle_cyc();

    // fill completely with varied error bits (R1, R4, R5, R8)
    for (int i = 0; i < DEPTH; i++)
      cyc(0, 1, 8'(8'h30 + i), i[0], i[1], i[2] & i[0], 0, 0, 0);
    idle_cyc();
    chk("R1 full count", int'(count_o), DEPTH);
    // overrun: push into full, with and without a concurrent pop (R3)
    cyc(0, 1, 8'hEE, 1, 1, 1, 0, 0, 0);
    cyc(0, 1, 8'hDD, 1, 1, 1, 1, 0, 0);
    idle_cyc();
    chk("R3 overrun sticky", int'(overrun_o), 1);

    // concurrent push and pop with error entries (R5)
    for (int i = 0; i < 10; i++)
      cyc(0, 1, 8'(8'hA0 + i), 0, i[0], i[1], 1, 0, 0);
    // drain past empty (R1, R2)
    for (int i = 0; i < DEPTH + 3; i++)
      cyc(0, 0, 8'h00, 0, 0, 0, 1, 0, 0);
    chk("R2 empty head", int'(head_data_o), 0);

    // idle timeout with data below trigger (R6)
    trig_lvl_i = 5'd4;
    for (int i = 0; i < 3; i++) cyc(0, 1, 8'(8'h50 + i), 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < IDLE + 3; i++) cyc(0, 0, 8'h00, 0, 0, 0, 0, 1, 0);
    chk("R6 idle expired", int'(data_ready_o), 1);
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 1, 1);      // busy masks and freezes
    cyc(0, 1, 8'h77, 0, 0, 1, 0, 1, 0);      // push restarts timer
    idle_cyc();
    chk("R6 restart after push", int'(data_ready_o), 0);
    for (int i = 0; i < IDLE; i++) cyc(0, 0, 8'h00, 0, 0, 0, 0, 1, 0);
    trig_lvl_i = 5'd2;                       // count now above trigger
    idle_cyc();
    chk("R6 above trigger", int'(data_ready_o), 0);

    // flush beats push and pop (R7)
    cyc(1, 1, 8'h99, 1, 1, 1, 1, 0, 0);
    chk("R7 flush count", int'(count_o), 0);
    chk("R7 flush tallies", int'(fer_cnt_o) + int'(per_cnt_o), 0);
    chk("R7 flush overrun", int'(overrun_o), 0);
    idle_cyc();

    // random traffic with changing levels
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        trig_lvl_i = 5'($urandom_range(0, DEPTH + 1));
        rts_lvl_i  = 5'($urandom_range(0, DEPTH + 1));
      end
      cyc(($urandom_range(0, 199) == 0), ($urandom_range(0, 2) != 0), 8'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 2) == 0),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0));
    end
    // quiet stretch so random data ages out
    trig_lvl_i = 5'd16;
    for (int i = 0; i < 4 * IDLE; i++) cyc(0, 0, 8'h00, 0, 0, 0, 0, 1, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule